// File: doc/BRIEF.md
# Console I/O Register Block

This block is a small peripheral that answers on a 16-bit address/data bus and links a processor to a character source (a keyboard) and a character sink (a display). It holds five registers: keyboard status, keyboard data, display status, display data and a machine control word. A character source strobes a byte in. A processor polls the ready flag or takes an interrupt, then reads the byte. Bytes written for the display are handed to the sink over a valid/ready handshake.

The top bit of both status words is a ready flag. Data accesses clear it as a side effect, and the flag comes back when new input arrives or when the sink takes the pending byte. The keyboard side raises an interrupt request only while a byte is waiting and software has set the enable flag. The request always carries priority 4 and vector 0x80. The top bit of the machine control word drives `run_en`. Clearing that bit tells the processor to stop processing instructions.

Bus reads are combinational: `bus_rdata` shows the addressed register in the same cycle that `bus_rd` is high. Writes and read side effects take effect at the next rising clock edge.

Top module: `console_io_regs`

## Requirements
- R1: After reset the keyboard status word reads 0x0000, the display status word reads 0x8000, the machine control word reads 0x8000, `irq_req` is low and `dsp_valid` is low.
- R2: A cycle with `kb_strobe` high sets bit 15 of the keyboard status word (address 0xFE00) and stores `kb_char`. A read of 0xFE02 then returns the stored byte in bits [7:0] with bits [15:8] zero.
- R3: A read of 0xFE02 clears the keyboard ready bit from the next cycle on. If `kb_strobe` is high in that same cycle, the new byte wins: the ready bit stays set and the new byte is stored.
- R4: Bit 14 of 0xFE00 is the keyboard interrupt enable and can be written. Bus writes never change the ready bit (bit 15).
- R5: A write to 0xFE06 while the display is idle puts `bus_wdata[7:0]` on `dsp_char` and raises `dsp_valid`. Bit 15 of 0xFE04 reads 0 until a cycle with `dsp_valid` and `dsp_ready` both high. After that cycle `dsp_valid` falls and bit 15 reads 1 again.
- R6: A write to 0xFE06 while `dsp_valid` is high is ignored, so `dsp_char` keeps the pending byte.
- R7: `irq_req` is high exactly when the keyboard ready bit and the enable bit are both set. `irq_prio` is always 4 and `irq_vec` is always 0x80.
- R8: Bit 15 of the machine control word (0xFFFE) can be written and drives `run_en`. Its other bits read as zero.
- R9: Reads of any address other than 0xFE00, 0xFE02, 0xFE04 and 0xFFFE return zero; this includes the write-only 0xFE06. Writes to addresses that are not decoded change no state.
- R10: `bus_rdata` is zero whenever `bus_rd` is low, and an address held without `bus_rd` causes no read side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Word address of the access |
| bus_rd | input | 1 | Read request for this cycle |
| bus_wr | input | 1 | Write request for this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when not reading |
| kb_strobe | input | 1 | One-cycle pulse: a new input byte is present |
| kb_char | input | 8 | Input byte qualified by `kb_strobe` |
| dsp_valid | output | 1 | A byte is waiting for the sink |
| dsp_char | output | 8 | Byte offered to the sink |
| dsp_ready | input | 1 | Sink accepts the byte in this cycle |
| run_en | output | 1 | Instruction processing allowed |
| irq_req | output | 1 | Keyboard interrupt request |
| irq_prio | output | 3 | Priority of the request |
| irq_vec | output | 8 | Vector of the request |

## Verification
The checker watches several rules on every clock. A strobe must leave the ready flag set, and a lone data read must clear it. The request line may only be high while a byte is waiting. A pending display byte must hold steady until accepted, must drop right after the handshake, and must survive a write made while busy. A control write must reach `run_en`, and read data must be zero while the bus is idle. Other properties depend on what software sees through the bus: that status writes leave the ready flag alone, that undecoded writes leave no trace, that a strobe beats a read in the same cycle, and the exact word layout of each register. Only the bench scenarios can show these, by reading the registers back and by following a behavioural model under long random traffic.

// File: rtl/console_pkg.sv
// Shared types for the console I/O register block.
// Assumes: one register selected per bus cycle at most.
package console_pkg;
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KSTAT,
        SEL_KDATA,
        SEL_DSTAT,
        SEL_DDATA,
        SEL_MCTL
    } reg_sel_e;
endpackage

// File: rtl/console_addr_dec.sv
// Address decoder: maps a bus address onto one register select.
// Assumes: full-width compare; any other address selects nothing.
module console_addr_dec
    import console_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] KSTAT_ADDR = 16'hFE00,
    parameter logic [15:0] KDATA_ADDR = 16'hFE02,
    parameter logic [15:0] DSTAT_ADDR = 16'hFE04,
    parameter logic [15:0] DDATA_ADDR = 16'hFE06,
    parameter logic [15:0] MCTL_ADDR  = 16'hFFFE
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Compare the address against each register location.
    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(KSTAT_ADDR))      sel = SEL_KSTAT;
        else if (addr == ADDR_W'(KDATA_ADDR)) sel = SEL_KDATA;
        else if (addr == ADDR_W'(DSTAT_ADDR)) sel = SEL_DSTAT;
        else if (addr == ADDR_W'(DDATA_ADDR)) sel = SEL_DDATA;
        else if (addr == ADDR_W'(MCTL_ADDR))  sel = SEL_MCTL;
    end
endmodule

// File: rtl/console_kbd_port.sv
// Keyboard side: captures strobed bytes, keeps the ready flag and the
// interrupt enable. Assumes: a strobe outranks a clearing read.
module console_kbd_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_strobe,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              data_rd,
    input  logic              ie_wr,
    input  logic              ie_wbit,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] char_q
);
    // Ready flag: set by a new byte, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)           ready <= 1'b0;
        else if (char_strobe) ready <= 1'b1;
        else if (data_rd)     ready <= 1'b0;
    end

    // Byte holder: last byte received.
    always_ff @(posedge clk) begin
        if (!rst_n)           char_q <= '0;
        else if (char_strobe) char_q <= char_in;
    end

    // Interrupt enable: written from the status word.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (ie_wr) ie <= ie_wbit;
    end
endmodule

// File: rtl/console_disp_port.sv
// Display side: holds one outgoing byte and offers it with valid/ready.
// Assumes: writes while a byte is pending are dropped.
module console_disp_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_wr,
    input  logic [CHAR_W-1:0] chr_wdata,
    input  logic              sink_ready,
    output logic              src_valid,
    output logic [CHAR_W-1:0] src_char,
    output logic              idle
);
    logic accept;
    assign accept = chr_wr && !src_valid;

    // Valid flag: raised by an accepted write, lowered by the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)                       src_valid <= 1'b0;
        else if (src_valid && sink_ready) src_valid <= 1'b0;
        else if (accept)                  src_valid <= 1'b1;
    end

    // Outgoing byte: loaded only when the port is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      src_char <= '0;
        else if (accept) src_char <= chr_wdata;
    end

    assign idle = !src_valid;
endmodule

// File: rtl/console_mctl_reg.sv
// Machine control flag: one writable run bit.
// Assumes: reset value chosen so the machine runs after reset.
module console_mctl_reg #(
    parameter logic RUN_RST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wbit,
    output logic run
);
    // Run flag: loaded from the bus on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)  run <= RUN_RST;
        else if (wr) run <= wbit;
    end
endmodule

// File: rtl/console_io_regs.sv
// Console I/O register block top: decodes bus cycles, multiplexes read
// data and drives the keyboard interrupt request.
// Assumes: combinational read data; side effects at the next rising edge.
module console_io_regs
    import console_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 16,
    parameter int          CHAR_W     = 8,
    parameter int          PRIO_W     = 3,
    parameter int          VEC_W      = 8,
    parameter int          KBD_PRIO   = 4,
    parameter int          KBD_VEC    = 128,
    parameter logic [15:0] KSTAT_ADDR = 16'hFE00,
    parameter logic [15:0] KDATA_ADDR = 16'hFE02,
    parameter logic [15:0] DSTAT_ADDR = 16'hFE04,
    parameter logic [15:0] DDATA_ADDR = 16'hFE06,
    parameter logic [15:0] MCTL_ADDR  = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kb_strobe,
    input  logic [CHAR_W-1:0] kb_char,
    output logic              dsp_valid,
    output logic [CHAR_W-1:0] dsp_char,
    input  logic              dsp_ready,
    output logic              run_en,
    output logic              irq_req,
    output logic [PRIO_W-1:0] irq_prio,
    output logic [VEC_W-1:0]  irq_vec
);
    localparam int RDY_BIT = DATA_W - 1;
    localparam int IE_BIT  = DATA_W - 2;

    reg_sel_e          sel;
    logic              kb_ready;
    logic              kb_ie;
    logic [CHAR_W-1:0] kb_char_q;
    logic              dsp_idle;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata[IE_BIT-1:CHAR_W];

    console_addr_dec #(
        .ADDR_W(ADDR_W), .KSTAT_ADDR(KSTAT_ADDR), .KDATA_ADDR(KDATA_ADDR),
        .DSTAT_ADDR(DSTAT_ADDR), .DDATA_ADDR(DDATA_ADDR), .MCTL_ADDR(MCTL_ADDR)
    ) dec_i (
        .addr(bus_addr),
        .sel (sel)
    );

    console_kbd_port #(.CHAR_W(CHAR_W)) kbd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_strobe(kb_strobe),
        .char_in    (kb_char),
        .data_rd    (bus_rd && sel == SEL_KDATA),
        .ie_wr      (bus_wr && sel == SEL_KSTAT),
        .ie_wbit    (bus_wdata[IE_BIT]),
        .ready      (kb_ready),
        .ie         (kb_ie),
        .char_q     (kb_char_q)
    );

    console_disp_port #(.CHAR_W(CHAR_W)) disp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr_wr    (bus_wr && sel == SEL_DDATA),
        .chr_wdata (bus_wdata[CHAR_W-1:0]),
        .sink_ready(dsp_ready),
        .src_valid (dsp_valid),
        .src_char  (dsp_char),
        .idle      (dsp_idle)
    );

    console_mctl_reg #(.RUN_RST(1'b1)) mctl_i (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (bus_wr && sel == SEL_MCTL),
        .wbit (bus_wdata[RDY_BIT]),
        .run  (run_en)
    );

    // Read multiplexer: place the selected register's fields on the bus.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_KSTAT: begin
                    bus_rdata[RDY_BIT] = kb_ready;
                    bus_rdata[IE_BIT]  = kb_ie;
                end
                SEL_KDATA: bus_rdata[CHAR_W-1:0] = kb_char_q;
                SEL_DSTAT: bus_rdata[RDY_BIT]    = dsp_idle;
                SEL_MCTL:  bus_rdata[RDY_BIT]    = run_en;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq_req  = kb_ready && kb_ie;
    assign irq_prio = PRIO_W'(KBD_PRIO);
    assign irq_vec  = VEC_W'(KBD_VEC);
endmodule

// File: rtl/console_io_chk.sv
// Protocol checker for console_io_regs, attached by bind.
// Assumes: observes ports plus the keyboard ready flag.
module console_io_chk #(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 16,
    parameter int          CHAR_W     = 8,
    parameter logic [15:0] KDATA_ADDR = 16'hFE02,
    parameter logic [15:0] DDATA_ADDR = 16'hFE06,
    parameter logic [15:0] MCTL_ADDR  = 16'hFFFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              wr_msb,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              kb_strobe,
    input logic              kb_ready,
    input logic              dsp_valid,
    input logic [CHAR_W-1:0] dsp_char,
    input logic              dsp_ready,
    input logic              run_en,
    input logic              irq_req
);
    p_kbd_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        kb_strobe |=> kb_ready);

    p_kbd_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(KDATA_ADDR) && !kb_strobe) |=> !kb_ready);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> kb_ready);

    p_dsp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_char)));

    p_dsp_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && dsp_ready) |=> !dsp_valid);

    p_busy_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && bus_wr && bus_addr == ADDR_W'(DDATA_ADDR)) |=> $stable(dsp_char));

    p_run_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(MCTL_ADDR)) |=> (run_en == $past(wr_msb)));

    p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind console_io_regs console_io_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
    .KDATA_ADDR(KDATA_ADDR), .DDATA_ADDR(DDATA_ADDR), .MCTL_ADDR(MCTL_ADDR)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .wr_msb   (bus_wdata[DATA_W-1]),
    .bus_rdata(bus_rdata),
    .kb_strobe(kb_strobe),
    .kb_ready (kb_ready),
    .dsp_valid(dsp_valid),
    .dsp_char (dsp_char),
    .dsp_ready(dsp_ready),
    .run_en   (run_en),
    .irq_req  (irq_req)
);

// File: tb/console_io_regs_tb_top.sv
// Bench: directed scenarios plus random traffic, compared every cycle
// against a behavioural model of the register block.
module console_io_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        kb_strobe = 1'b0;
    logic [7:0]  kb_char = '0;
    logic        dsp_valid;
    logic [7:0]  dsp_char;
    logic        dsp_ready = 1'b0;
    logic        run_en;
    logic        irq_req;
    logic [2:0]  irq_prio;
    logic [7:0]  irq_vec;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    // Behavioural model state.
    bit       m_krdy, m_kie, m_dbusy, m_run;
    bit [7:0] m_kchr, m_dchr;

    always #10 clk = ~clk;   // 50 MHz

    console_io_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kb_strobe(kb_strobe), .kb_char(kb_char), .dsp_valid(dsp_valid),
        .dsp_char(dsp_char), .dsp_ready(dsp_ready), .run_en(run_en),
        .irq_req(irq_req), .irq_prio(irq_prio), .irq_vec(irq_vec)
    );

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] model_rdata();
        if (!bus_rd) return 16'h0000;
        case (bus_addr)
            16'hFE00: return {m_krdy, m_kie, 14'h0};
            16'hFE02: return {8'h00, m_kchr};
            16'hFE04: return {!m_dbusy, 15'h0};
            16'hFFFE: return {m_run, 15'h0};
            default:  return 16'h0000;
        endcase
    endfunction

    // Model update at each rising edge, from the inputs held this cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_krdy = 0; m_kie = 0; m_dbusy = 0; m_run = 1; m_kchr = 0; m_dchr = 0;
        end else begin
            if (kb_strobe) begin m_krdy = 1; m_kchr = kb_char; end
            else if (bus_rd && bus_addr == 16'hFE02) m_krdy = 0;
            if (bus_wr && bus_addr == 16'hFE00) m_kie = bus_wdata[14];
            if (bus_wr && bus_addr == 16'hFFFE) m_run = bus_wdata[15];
            if (m_dbusy && dsp_ready) m_dbusy = 0;
            else if (!m_dbusy && bus_wr && bus_addr == 16'hFE06) begin
                m_dbusy = 1; m_dchr = bus_wdata[7:0];
            end
        end
    end

    // Cycle comparison against the model, at the falling edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(bus_rdata, model_rdata(), "R2/R9 read data vs model");
            chk({15'h0, dsp_valid}, {15'h0, m_dbusy}, "R5 dsp_valid vs model");
            if (m_dbusy) chk({8'h0, dsp_char}, {8'h0, m_dchr}, "R6 dsp_char vs model");
            chk({15'h0, run_en}, {15'h0, m_run}, "R8 run_en vs model");
            chk({15'h0, irq_req}, {15'h0, m_krdy & m_kie}, "R7 irq_req vs model");
        end
    end

    // One bus cycle: drive just after the falling edge, hold for a cycle.
    task automatic op(input bit rd, input bit wr, input logic [15:0] a,
                      input logic [15:0] wd, input bit ks = 0, input logic [7:0] kc = 0);
        @(negedge clk); #1;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        kb_strobe = ks; kb_char = kc;
    endtask

    task automatic idle();
        op(0, 0, 16'h0000, 16'h0000);
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [15:0] exp, input string tag);
        op(1, 0, a, 16'h0000);
        #5 chk(bus_rdata, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1: reset values
        rd_chk(16'hFE00, 16'h0000, "R1 kbd status after reset");
        rd_chk(16'hFE04, 16'h8000, "R1 display status after reset");
        rd_chk(16'hFFFE, 16'h8000, "R1 control word after reset");
        chk({14'h0, irq_req, dsp_valid}, 16'h0000, "R1 irq and dsp_valid low");

        // R2: strobe sets ready and stores byte
        op(0, 0, 16'h0000, 16'h0000, 1, 8'h41);
        rd_chk(16'hFE00, 16'h8000, "R2 ready set after strobe");
        rd_chk(16'hFE02, 16'h0041, "R2 byte readback");
        rd_chk(16'hFE00, 16'h0000, "R3 ready cleared after data read");

        // R3: strobe in same cycle as clearing read wins
        op(0, 0, 16'h0000, 16'h0000, 1, 8'h42);
        op(1, 0, 16'hFE02, 16'h0000, 1, 8'h43);
        #5 chk(bus_rdata, 16'h0042, "R3 old byte read in collision cycle");
        rd_chk(16'hFE00, 16'h8000, "R3 strobe wins over read");
        rd_chk(16'hFE02, 16'h0043, "R3 new byte stored");

        // R4/R7: enable bit writable, ready bit read-only, irq gating
        op(0, 1, 16'hFE00, 16'hFFFF);
        rd_chk(16'hFE00, 16'h4000, "R4 ie set, ready not written");
        chk({15'h0, irq_req}, 16'h0000, "R7 no irq without byte");
        op(0, 0, 16'h0000, 16'h0000, 1, 8'h44);
        idle();
        #5 chk({15'h0, irq_req}, 16'h0001, "R7 irq with byte and ie");
        chk({5'h0, irq_prio, irq_vec}, 16'h0480, "R7 priority and vector");
        op(0, 1, 16'hFE00, 16'h0000);
        rd_chk(16'hFE00, 16'h8000, "R4 ie cleared, ready kept");
        chk({15'h0, irq_req}, 16'h0000, "R7 irq masked by ie");
        op(0, 1, 16'hFE00, 16'h4000);
        rd_chk(16'hFE02, 16'h0044, "R2 byte readback");
        idle();
        #5 chk({15'h0, irq_req}, 16'h0000, "R7 irq drops after data read");

        // R5/R6: display handshake
        dsp_ready = 1'b0;
        op(0, 1, 16'hFE06, 16'h1234);
        idle();
        #5 chk({7'h0, dsp_valid, dsp_char}, 16'h0134, "R5 byte offered");
        rd_chk(16'hFE04, 16'h0000, "R5 display busy");
        op(0, 1, 16'hFE06, 16'h0055);
        idle();
        #5 chk({7'h0, dsp_valid, dsp_char}, 16'h0134, "R6 busy write ignored");
        @(negedge clk); #1 dsp_ready = 1'b1;
        @(negedge clk); #1 dsp_ready = 1'b0;
        #5 chk({15'h0, dsp_valid}, 16'h0000, "R5 valid drops after handshake");
        rd_chk(16'hFE04, 16'h8000, "R5 display ready again");
        rd_chk(16'hFE06, 16'h0000, "R9 display data reads zero");

        // R8: control word
        op(0, 1, 16'hFFFE, 16'h0000);
        rd_chk(16'hFFFE, 16'h0000, "R8 run bit cleared");
        chk({15'h0, run_en}, 16'h0000, "R8 run_en low");
        op(0, 1, 16'hFFFE, 16'hFFFF);
        rd_chk(16'hFFFE, 16'h8000, "R8 only bit 15 kept");
        chk({15'h0, run_en}, 16'h0001, "R8 run_en high");

        // R9: undecoded addresses
        op(0, 1, 16'hFE08, 16'hFFFF);
        op(0, 1, 16'hFFFC, 16'h0000);
        op(0, 1, 16'hFE01, 16'h0000);
        rd_chk(16'hFE08, 16'h0000, "R9 undecoded read zero");
        rd_chk(16'hFE01, 16'h0000, "R9 odd address read zero");
        rd_chk(16'h3000, 16'h0000, "R9 out-of-range read zero");
        rd_chk(16'hFE00, 16'h4000, "R9 kbd status untouched");
        rd_chk(16'hFFFE, 16'h8000, "R9 control untouched");

        // R10: no read, no side effect
        op(0, 0, 16'h0000, 16'h0000, 1, 8'h5A);
        op(0, 0, 16'hFFFE, 16'h0000);
        #5 chk(bus_rdata, 16'h0000, "R10 rdata zero when idle");
        op(0, 0, 16'hFE02, 16'h0000);
        rd_chk(16'hFE00, 16'hC000, "R10 ready kept without read");

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] addrs [6] = '{16'hFE00, 16'hFE02, 16'hFE04, 16'hFE06, 16'hFFFE, 16'hFE08};
            int kind = $urandom_range(0, 2);
            op(kind == 1, kind == 2, addrs[$urandom_range(0, 5)], 16'($urandom),
               ($urandom_range(0, 7) == 0), 8'($urandom));
            dsp_ready = ($urandom_range(0, 3) == 0);
        end
        idle();
        dsp_ready = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule